// File: doc/BRIEF.md
# Bit-Field Extract and Flag-Pack Unit

A 32-bit datapath helper for interpreter-style integer code. In a single operation it can pull an arbitrary field out of a register and widen it with zeros or with its own top bit. It can also turn a comparison between two operands into a small integer, or produce either a value or zero depending on an external condition. The field position and field size come together from one 9-bit control word held in the low bits of the S operand. This lets a compact immediate describe fields of up to 15 bits at any offset.

Each operation is presented with a valid strobe. The result appears on the registered output one clock later, together with a matching valid flag. Instruction decoding and the register file lie outside the block.

Top module: `bfx_unit`

## Requirements
- R1: With op_i = 0 (zero-extend extract), the result is (d_i >> s_i[4:0]) AND ((1 << s_i[8:5]) - 1).
- R2: With op_i = 1 (sign-extend extract), the result holds the same field in its low s_i[8:5] bits. Every bit above the field is a copy of bit s_i[8:5]-1 of d_i >> s_i[4:0].
- R3: A field width s_i[8:5] of 0 gives a result of 0 in both extract modes.
- R4: With op_i = 2 (flag pack), result bits [31:2] are 0, bit 1 is Z (d_i equals s_i) and bit 0 is C (d_i less than s_i).
- R5: The less-than test used for C treats d_i and s_i as two's-complement when signed_i is 1 and as unsigned when signed_i is 0.
- R6: With op_i = 3 (set from carry), the result is 1 when C is set and 0 otherwise, with bits [31:1] always 0.
- R7: With op_i = 4 (conditional set), the result is s_i when cond_i is 1 and 0 when cond_i is 0; the result is written in both cases.
- R8: The result and valid_o appear one clock after the valid_i cycle; valid_o is valid_i delayed by one clock.
- R9: While valid_i is 0, result_o keeps its value. Reset clears result_o and valid_o to 0.
- R10: The unused op_i codes 5, 6 and 7 produce a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation select (0 zext, 1 sext, 2 flags, 3 setc, 4 csel) |
| d_i | input | 32 | D operand |
| s_i | input | 32 | S operand; bits [8:0] are the extract control |
| cond_i | input | 1 | Condition-true input for conditional set |
| signed_i | input | 1 | Selects a signed less-than compare |
| valid_o | output | 1 | Result valid, one clock after valid_i |
| result_o | output | 32 | Registered result |

## Verification
The assertions assume that valid_i and every operand are stable and known at each rising edge, and that valid_i is held low while reset is active. They also assume that op_i carries one of the five defined codes whenever a property keyed on a code is meant to fire. The stimulus changes inputs only on falling edges and keeps valid_i at 0 until reset has been released. It sweeps all 512 control words in both extract modes and pairs corner operands, including the sign boundaries, in both compare modes.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  typedef enum logic [2:0] {
    OP_EXT_Z = 3'd0,
    OP_EXT_S = 3'd1,
    OP_FLAGS = 3'd2,
    OP_SETC  = 3'd3,
    OP_CSEL  = 3'd4
  } bfx_op_e;
endpackage

// File: rtl/bfx_extract.sv
module bfx_extract #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W),
  parameter int FW_W   = 4,
  localparam int CTL_W = SH_W + FW_W
) (
  input  logic [DATA_W-1:0] d_i,
  input  logic [CTL_W-1:0]  ctl_i,
  output logic [DATA_W-1:0] zext_o,
  output logic [DATA_W-1:0] sext_o
);
  logic [SH_W-1:0]   sh;
  logic [FW_W-1:0]   w;
  logic [DATA_W-1:0] shifted, mask, field;
  logic [FW_W-1:0]   top_idx;
  logic              sign_bit;

  assign sh      = ctl_i[SH_W-1:0];
  assign w       = ctl_i[CTL_W-1:SH_W];
  assign shifted = d_i >> sh;
  assign mask    = ~({DATA_W{1'b1}} << w);
  assign field   = shifted & mask;
  assign top_idx = w - FW_W'(1);
  // width 0 has no top bit: force sign to zero
  assign sign_bit = (w != '0) && shifted[top_idx];
  assign zext_o   = field;
  assign sext_o   = field | (sign_bit ? ~mask : '0);
endmodule

// File: rtl/bfx_compare.sv
module bfx_compare #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              signed_i,
  output logic              eq_o,
  output logic              lt_o
);
  assign eq_o = (a_i == b_i);
  assign lt_o = signed_i ? ($signed(a_i) < $signed(b_i)) : (a_i < b_i);
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FW_W   = 4,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int CTL_W = SH_W + FW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] d_i,
  input  logic [DATA_W-1:0] s_i,
  input  logic              cond_i,
  input  logic              signed_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  bfx_op_e           op;
  logic [DATA_W-1:0] zext, sext, nxt;
  logic              eq, lt;

  assign op = bfx_op_e'(op_i);

  bfx_extract #(.DATA_W(DATA_W), .SH_W(SH_W), .FW_W(FW_W)) u_ext (
    .d_i    (d_i),
    .ctl_i  (s_i[CTL_W-1:0]),
    .zext_o (zext),
    .sext_o (sext)
  );

  bfx_compare #(.DATA_W(DATA_W)) u_cmp (
    .a_i      (d_i),
    .b_i      (s_i),
    .signed_i (signed_i),
    .eq_o     (eq),
    .lt_o     (lt)
  );

  always_comb begin
    unique case (op)
      OP_EXT_Z: nxt = zext;
      OP_EXT_S: nxt = sext;
      OP_FLAGS: nxt = {{(DATA_W-2){1'b0}}, eq, lt};
      OP_SETC:  nxt = {{(DATA_W-1){1'b0}}, lt};
      OP_CSEL:  nxt = cond_i ? s_i : '0;
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= nxt;
    end
  end
endmodule

// File: rtl/bfx_checker.sv
module bfx_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] d_i,
  input logic [DATA_W-1:0] s_i,
  input logic              cond_i,
  input logic              signed_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o
);
  a_r8_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r8_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  a_r1_zext_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd0) |=> ((result_o >> $past(s_i[8:5])) == '0));
  a_r3_zero_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i inside {3'd0, 3'd1} && s_i[8:5] == 4'd0) |=> (result_o == '0));
  a_r4_flags_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2) |=> (result_o[DATA_W-1:2] == '0));
  a_r6_setc_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd3) |=> (result_o[DATA_W-1:1] == '0));
  a_r7_csel_true: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4 && cond_i) |=> (result_o == $past(s_i)));
  a_r7_csel_false: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4 && !cond_i) |=> (result_o == '0));
  a_r10_unused_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 3'd4) |=> (result_o == '0));
endmodule

bind bfx_unit bfx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .d_i      (d_i),
  .s_i      (s_i),
  .cond_i   (cond_i),
  .signed_i (signed_i),
  .valid_o  (valid_o),
  .result_o (result_o)
);

// File: tb/tb_bfx_unit.sv
module tb_bfx_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] d_i = '0, s_i = '0;
  logic        cond_i = 1'b0, signed_i = 1'b0;
  logic        valid_o;
  logic [31:0] result_o;
  int n_chk = 0, n_bad = 0;

  always #2 clk_i = ~clk_i;

  bfx_unit dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [31:0] d, input logic [31:0] s,
                        input logic c, input logic sg);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; d_i = d; s_i = s; cond_i = c; signed_i = sg;
    @(negedge clk_i);
  endtask

  function automatic logic [31:0] exp_zext(input logic [31:0] d, input logic [8:0] c);
    logic [31:0] sh = d >> c[4:0];
    return sh & ((32'd1 << c[8:5]) - 32'd1);
  endfunction

  function automatic logic [31:0] exp_sext(input logic [31:0] d, input logic [8:0] c);
    logic [31:0] f = exp_zext(d, c);
    int w = int'(c[8:5]);
    if (w == 0) return 32'd0;
    if (f[w-1]) return f | ~((32'd1 << w) - 32'd1);
    return f;
  endfunction

  function automatic logic exp_lt(input logic [31:0] a, input logic [31:0] b, input logic sg);
    return sg ? ($signed(a) < $signed(b)) : (a < b);
  endfunction

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", n_chk, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] dv [4];
    logic [31:0] cv [6];
    logic [31:0] last;
    dv[0] = 32'hDEADBEEF; dv[1] = 32'h5A5A_A5A5; dv[2] = 32'hFFFF_FFFF; dv[3] = 32'h8000_7FFF;
    cv[0] = 32'h0; cv[1] = 32'h1; cv[2] = 32'h7FFF_FFFF;
    cv[3] = 32'h8000_0000; cv[4] = 32'hFFFF_FFFF; cv[5] = 32'h1234_5678;

    #9;
    check("R9 reset result", result_o, 32'd0);
    check("R9 reset valid", {31'd0, valid_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 R2 R3 exhaustive control sweep
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 512; c++) begin
        run_op(3'd0, dv[k], 32'hFFFF_FE00 | 32'(c), 1'b0, 1'b0);
        check(c[8:5] == 0 ? "R3 zext w0" : "R1 zext", result_o, exp_zext(dv[k], 9'(c)));
        check("R8 valid", {31'd0, valid_o}, 32'd1);
        run_op(3'd1, dv[k], 32'(c), 1'b0, 1'b0);
        check(c[8:5] == 0 ? "R3 sext w0" : "R2 sext", result_o, exp_sext(dv[k], 9'(c)));
      end

    // R4 R5 R6 compare pairs
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++)
        for (int sg = 0; sg < 2; sg++) begin
          run_op(3'd2, cv[a], cv[b], 1'b0, sg[0]);
          check(sg ? "R4 R5 flags signed" : "R4 flags unsigned", result_o,
                {30'd0, cv[a] == cv[b], exp_lt(cv[a], cv[b], sg[0])});
          run_op(3'd3, cv[a], cv[b], 1'b0, sg[0]);
          check(sg ? "R6 R5 setc signed" : "R6 setc unsigned", result_o,
                {31'd0, exp_lt(cv[a], cv[b], sg[0])});
        end

    // R7 conditional set
    for (int a = 0; a < 6; a++) begin
      run_op(3'd4, 32'hAAAA_5555, cv[a], 1'b1, 1'b0);
      check("R7 csel true", result_o, cv[a]);
      run_op(3'd4, 32'hAAAA_5555, 32'hCAFE_F00D, 1'b0, 1'b0);
      check("R7 csel false", result_o, 32'd0);
    end

    // R10 unused codes
    for (int o = 5; o < 8; o++) begin
      run_op(3'd4, 32'd0, 32'h1357_9BDF, 1'b1, 1'b0);
      run_op(3'(o), 32'hFFFF_FFFF, 32'h0000_01E0, 1'b1, 1'b1);
      check("R10 unused op", result_o, 32'd0);
    end

    // R8 R9 hold with valid low
    run_op(3'd4, 32'd0, 32'h0BAD_F00D, 1'b1, 1'b0);
    last = result_o;
    valid_i = 1'b0; op_i = 3'd0; d_i = 32'hFFFF_FFFF; s_i = 32'h0000_01E0;
    @(negedge clk_i);
    check("R8 valid low", {31'd0, valid_o}, 32'd0);
    check("R9 hold", result_o, last);
    @(negedge clk_i);
    check("R9 hold 2", result_o, 32'h0BAD_F00D);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule